// File: doc/BRIEF.md
# Free-Region Allocator

This block manages free space in a word-addressed memory. It holds a small table of free regions, each a valid flag, a base address and a size in words. A requester asks for a block of n words and picks one of two placement policies. The block then walks the table one entry per clock and replies with a granted base address, or with an overflow indication when no free region is big enough. Only free, unoccupied space is ever used. No region is moved and no block is displaced to make room.

Under the lowest-index policy, the scan stops at the first valid entry that holds at least n words. Under the tightest-fit policy, the scan reads every entry and picks the smallest region that still holds n words. If two such regions have the same size, the lower index wins. When a region is granted, its base moves up by n and its size drops by n. A region whose size reaches zero leaves the table. A release request puts a region back into the lowest unused slot, with no merging of neighbouring regions. When every slot is in use, or the released size is zero, the release is refused with an error flag.

A typical use: release (50,250), (400,300) and (800,200) into an empty table. With the lowest-index policy, requests for 100 and then 250 words get bases 50 and 400. With the tightest-fit policy, the same two requests get bases 800 and 50.

Top module: `region_alloc`

## Requirements
- R1: After reset the table is empty, `busy_o`, `alloc_done_o` and `free_done_o` are low, and the first allocation request reports overflow.
- R2: A release is accepted while `busy_o` is low. Its size must be nonzero and a slot must be unused. The release is written into the lowest-index unused slot, with no merging, and `free_done_o` pulses for one cycle in the next cycle with `free_err_o` low.
- R3: A release whose size is zero, or that arrives when all 8 slots are in use, gives a `free_done_o` pulse with `free_err_o` high and leaves the table unchanged.
- R4: With `alloc_best_i`=0 (lowest-index policy), the grant is the valid entry with the lowest index k whose size is at least n. `alloc_done_o` pulses k+2 cycles after the cycle that accepts the request.
- R5: With `alloc_best_i`=1 (tightest-fit policy), the grant is the valid entry of minimum size among those with size at least n, the lowest index winning ties. `alloc_done_o` pulses 9 cycles after acceptance (one cycle per table entry, plus one).
- R6: On a grant, `alloc_base_o` is the entry's base. The entry's base then increases by n and its size decreases by n. An entry whose size reaches zero becomes unused, so the next release can take its slot.
- R7: When no valid entry holds n words, or n is zero, `alloc_done_o` pulses 9 cycles after acceptance with `alloc_ovf_o` high, `alloc_ok_o` low and `alloc_base_o` zero, and the table is unchanged.
- R8: `busy_o` is high from the cycle after an allocation is accepted until `alloc_done_o` pulses. Allocation and release requests that arrive while `busy_o` is high are ignored.
- R9: An allocation and a release that arrive in the same idle cycle are both accepted. The release is written first, and the allocation scan sees the released region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Allocation request strobe |
| alloc_size_i | input | 16 | Words requested (n) |
| alloc_best_i | input | 1 | Policy: 0 lowest-index, 1 tightest-fit |
| free_req_i | input | 1 | Release request strobe |
| free_base_i | input | 16 | Base of the released region |
| free_size_i | input | 16 | Size of the released region |
| busy_o | output | 1 | Allocation scan in progress |
| alloc_done_o | output | 1 | One-cycle pulse: allocation result valid |
| alloc_ok_o | output | 1 | Grant made (with done) |
| alloc_ovf_o | output | 1 | No region fits (with done) |
| alloc_base_o | output | 16 | Granted base, zero on overflow (with done) |
| free_done_o | output | 1 | One-cycle pulse: release handled |
| free_err_o | output | 1 | Release refused (with free done) |

## Verification
An allocation request and a release request can arrive in the same idle cycle. The release then has to land in the table before the scan reads entry 0. The bench provokes this in two ways. First, it offers a release that is the only region able to satisfy the request. Second, it issues mixed random operations where both strobes often rise together. A reference model applies the release before it searches its own region list and predicts the grant, the overflow flag and the exact done cycle. The bench also sends strobes while a scan is running and checks that neither request changes any later result.

// File: rtl/region_pkg.sv
package region_pkg;
  typedef enum logic {
    FIT_FIRST = 1'b0,
    FIT_BEST  = 1'b1
  } fit_e;
endpackage

// File: rtl/region_table.sv
module region_table #(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] rd_idx_i,
  output logic          rd_vld_o,
  output logic [AW-1:0] rd_base_o,
  output logic [AW-1:0] rd_size_o,
  input  logic          ins_en_i,
  input  logic [AW-1:0] ins_base_i,
  input  logic [AW-1:0] ins_size_i,
  output logic          ins_ok_o,
  input  logic          upd_en_i,
  input  logic [IW-1:0] upd_idx_i,
  input  logic [AW-1:0] upd_n_i
);
  logic          vld_q  [N];
  logic [AW-1:0] base_q [N];
  logic [AW-1:0] size_q [N];
  logic [N-1:0]  vld_vec;
  logic [IW-1:0] slot;
  logic          found;

  // lowest unused slot
  always_comb begin
    slot  = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        found = 1'b1;
        slot  = IW'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) vld_vec[i] = vld_q[i];
  end

  assign ins_ok_o  = found;
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign rd_base_o = base_q[rd_idx_i];
  assign rd_size_o = size_q[rd_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        base_q[g] <= '0;
        size_q[g] <= '0;
      end else if (ins_en_i && found && slot == IW'(g)) begin
        vld_q[g]  <= 1'b1;
        base_q[g] <= ins_base_i;
        size_q[g] <= ins_size_i;
      end else if (upd_en_i && upd_idx_i == IW'(g)) begin
        base_q[g] <= base_q[g] + upd_n_i;
        size_q[g] <= size_q[g] - upd_n_i;
        vld_q[g]  <= (size_q[g] != upd_n_i);
      end
    end
  end

  AST_GRANT_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |-> (vld_q[upd_idx_i] && upd_n_i != '0 && size_q[upd_idx_i] >= upd_n_i)); // R6
  AST_INSERT_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_en_i && ins_ok_o && !upd_en_i) |=> ($countones(vld_vec) == $past($countones(vld_vec)) + 1)); // R2
  AST_EMPTY_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && size_q[upd_idx_i] == upd_n_i) |=> !vld_vec[$past(upd_idx_i)]); // R6
endmodule

// File: rtl/region_scan.sv
module region_scan
  import region_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] size_i,
  input  fit_e          fit_i,
  output logic [IW-1:0] idx_o,
  input  logic          rd_vld_i,
  input  logic [AW-1:0] rd_base_i,
  input  logic [AW-1:0] rd_size_i,
  output logic          upd_en_o,
  output logic [IW-1:0] upd_idx_o,
  output logic [AW-1:0] upd_n_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ok_o,
  output logic          ovf_o,
  output logic [AW-1:0] base_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic          busy_q, done_q, ok_q, ovf_q, hit_q;
  logic [IW-1:0] idx_q, bidx_q;
  logic [AW-1:0] n_q, bsize_q, bbase_q, base_q;
  fit_e          fit_q;

  logic          fits, better, finish, grant;
  logic [IW-1:0] gidx;
  logic [AW-1:0] gbase;

  assign fits   = busy_q && rd_vld_i && n_q != '0 && rd_size_i >= n_q;
  assign better = fits && (!hit_q || rd_size_i < bsize_q);
  assign finish = busy_q && ((fit_q == FIT_FIRST && fits) || idx_q == LAST);

  always_comb begin
    if (fit_q == FIT_FIRST) begin
      grant = fits;
      gidx  = idx_q;
      gbase = rd_base_i;
    end else if (better) begin
      grant = 1'b1;
      gidx  = idx_q;
      gbase = rd_base_i;
    end else begin
      grant = hit_q;
      gidx  = bidx_q;
      gbase = bbase_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      ovf_q   <= 1'b0;
      base_q  <= '0;
      hit_q   <= 1'b0;
      idx_q   <= '0;
      bidx_q  <= '0;
      bsize_q <= '0;
      bbase_q <= '0;
      n_q     <= '0;
      fit_q   <= FIT_FIRST;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        hit_q  <= 1'b0;
        n_q    <= size_i;
        fit_q  <= fit_i;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        ok_q   <= grant;
        ovf_q  <= !grant;
        base_q <= grant ? gbase : '0;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        if (better) begin
          hit_q   <= 1'b1;
          bidx_q  <= idx_q;
          bsize_q <= rd_size_i;
          bbase_q <= rd_base_i;
        end
      end
    end
  end

  assign idx_o     = idx_q;
  assign upd_en_o  = finish && grant;
  assign upd_idx_o = gidx;
  assign upd_n_o   = n_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign ok_o      = ok_q;
  assign ovf_o     = ovf_q;
  assign base_o    = base_q;

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R8
  AST_DONE_ENDS_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q))); // R8
  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (ok_q != ovf_q)); // R7
  AST_OVF_BASE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && ovf_q) |-> base_q == '0); // R7
endmodule

// File: rtl/region_alloc.sv
module region_alloc
  import region_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_req_i,
  input  logic [AW-1:0] alloc_size_i,
  input  logic          alloc_best_i,
  input  logic          free_req_i,
  input  logic [AW-1:0] free_base_i,
  input  logic [AW-1:0] free_size_i,
  output logic          busy_o,
  output logic          alloc_done_o,
  output logic          alloc_ok_o,
  output logic          alloc_ovf_o,
  output logic [AW-1:0] alloc_base_o,
  output logic          free_done_o,
  output logic          free_err_o
);
  localparam int IW = $clog2(N);

  logic          busy, start, free_en, ins_en, ins_ok;
  logic          rd_vld, upd_en;
  logic [IW-1:0] rd_idx, upd_idx;
  logic [AW-1:0] rd_base, rd_size, upd_n;
  logic          free_done_q, free_err_q;
  fit_e          fit;

  assign start   = alloc_req_i && !busy;
  assign free_en = free_req_i && !busy;
  assign ins_en  = free_en && free_size_i != '0;
  assign fit     = alloc_best_i ? FIT_BEST : FIT_FIRST;

  region_table #(.N(N), .AW(AW), .IW(IW)) i_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_vld_o   (rd_vld),
    .rd_base_o  (rd_base),
    .rd_size_o  (rd_size),
    .ins_en_i   (ins_en),
    .ins_base_i (free_base_i),
    .ins_size_i (free_size_i),
    .ins_ok_o   (ins_ok),
    .upd_en_i   (upd_en),
    .upd_idx_i  (upd_idx),
    .upd_n_i    (upd_n)
  );

  region_scan #(.N(N), .AW(AW), .IW(IW)) i_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .size_i    (alloc_size_i),
    .fit_i     (fit),
    .idx_o     (rd_idx),
    .rd_vld_i  (rd_vld),
    .rd_base_i (rd_base),
    .rd_size_i (rd_size),
    .upd_en_o  (upd_en),
    .upd_idx_o (upd_idx),
    .upd_n_o   (upd_n),
    .busy_o    (busy),
    .done_o    (alloc_done_o),
    .ok_o      (alloc_ok_o),
    .ovf_o     (alloc_ovf_o),
    .base_o    (alloc_base_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_done_q <= 1'b0;
      free_err_q  <= 1'b0;
    end else begin
      free_done_q <= free_en;
      if (free_en) free_err_q <= !ins_ok || free_size_i == '0;
    end
  end

  assign busy_o      = busy;
  assign free_done_o = free_done_q;
  assign free_err_o  = free_err_q;

  AST_NO_FREE_IN_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && free_req_i) |=> !free_done_o); // R8
  AST_ZERO_FREE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_en && free_size_i == '0) |=> (free_done_o && free_err_o)); // R3
endmodule

// File: tb/test_region_alloc.sv
module test_region_alloc;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_req_i = 1'b0, alloc_best_i = 1'b0;
  logic [15:0] alloc_size_i = '0;
  logic        free_req_i = 1'b0;
  logic [15:0] free_base_i = '0, free_size_i = '0;
  logic        busy_o, alloc_done_o, alloc_ok_o, alloc_ovf_o, free_done_o, free_err_o;
  logic [15:0] alloc_base_o;

  always #5 clk = ~clk;

  region_alloc i_region_alloc (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_req_i(alloc_req_i), .alloc_size_i(alloc_size_i), .alloc_best_i(alloc_best_i),
    .free_req_i(free_req_i), .free_base_i(free_base_i), .free_size_i(free_size_i),
    .busy_o(busy_o), .alloc_done_o(alloc_done_o), .alloc_ok_o(alloc_ok_o),
    .alloc_ovf_o(alloc_ovf_o), .alloc_base_o(alloc_base_o),
    .free_done_o(free_done_o), .free_err_o(free_err_o)
  );

  // behavioural reference
  logic        m_vld [N];
  logic [15:0] m_base [N];
  logic [15:0] m_size [N];
  logic        m_busy, e_adone, e_aok, e_aovf, e_fdone, e_ferr;
  logic [15:0] e_abase, p_base, p_n;
  int          m_cnt, p_idx;
  logic        p_ok;

  int    checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_base[i] = 0; m_size[i] = 0; end
      m_busy = 0; e_adone = 0; e_aok = 0; e_aovf = 0; e_abase = 0; e_fdone = 0; e_ferr = 0;
      m_cnt = 0;
    end else begin
      e_adone = 0;
      e_fdone = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; e_adone = 1; e_aok = p_ok; e_aovf = !p_ok;
          e_abase = p_ok ? p_base : 16'd0;
          if (p_ok) begin
            m_base[p_idx] = m_base[p_idx] + p_n;
            m_size[p_idx] = m_size[p_idx] - p_n;
            if (m_size[p_idx] == 0) m_vld[p_idx] = 0;
          end
        end
      end else begin
        if (free_req_i) begin
          int slot;
          slot = -1;
          for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
          e_fdone = 1;
          e_ferr = (free_size_i == 0) || (slot < 0);
          if (!e_ferr) begin
            m_vld[slot] = 1; m_base[slot] = free_base_i; m_size[slot] = free_size_i;
          end
        end
        if (alloc_req_i) begin
          p_ok = 0; p_idx = 0; p_n = alloc_size_i; p_base = 0; m_cnt = N;
          for (int i = 0; i < N; i++) begin
            if (m_vld[i] && p_n != 0 && m_size[i] >= p_n) begin
              if (!alloc_best_i) begin
                if (!p_ok) begin p_ok = 1; p_idx = i; m_cnt = i + 1; end
              end else if (!p_ok || m_size[i] < m_size[p_idx]) begin
                p_ok = 1; p_idx = i;
              end
            end
          end
          if (p_ok) p_base = m_base[p_idx];
          m_busy = 1;
        end
      end
    end
  end

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      chk("busy", 16'(busy_o), 16'(m_busy));
      chk("alloc_done", 16'(alloc_done_o), 16'(e_adone));
      chk("free_done", 16'(free_done_o), 16'(e_fdone));
      if (e_adone) begin
        chk("alloc_ok", 16'(alloc_ok_o), 16'(e_aok));
        chk("alloc_ovf", 16'(alloc_ovf_o), 16'(e_aovf));
        chk("alloc_base", alloc_base_o, e_abase);
      end
      if (e_fdone) chk("free_err", 16'(free_err_o), 16'(e_ferr));
    end
  end

  task automatic drive(input logic a, input logic [15:0] n, input logic best,
                       input logic f, input logic [15:0] fb, input logic [15:0] fs);
    @(negedge clk);
    alloc_req_i = a; alloc_size_i = n; alloc_best_i = best;
    free_req_i = f; free_base_i = fb; free_size_i = fs;
    @(negedge clk);
    alloc_req_i = 0; free_req_i = 0;
  endtask

  task automatic settle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_free(input logic [15:0] b, input logic [15:0] s);
    drive(0, 0, 0, 1, b, s); settle();
  endtask

  task automatic do_alloc(input logic [15:0] n, input logic best);
    drive(1, n, best, 0, 0, 0); settle();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_example();
    do_free(50, 250); do_free(400, 300); do_free(800, 200);
  endtask

  initial begin
    do_reset();
    cur_req = "R1"; repeat (3) @(negedge clk);
    do_alloc(10, 0);                       // empty table: overflow
    cur_req = "R2"; load_example();
    cur_req = "R4"; do_alloc(100, 0); do_alloc(250, 0);   // 50, then 400
    cur_req = "R6"; do_alloc(150, 0);      // takes rest of entry 0, retires it
    cur_req = "R2"; do_free(2000, 40);     // lands in slot 0
    cur_req = "R6"; do_alloc(40, 0);       // slot 0 hit, base 2000
    do_reset();
    cur_req = "R2"; load_example();
    cur_req = "R5"; do_alloc(100, 1); do_alloc(250, 1);   // 800, then 50
    do_free(3000, 50); do_free(3100, 50);  // equal sizes
    do_alloc(50, 1);                       // tie: lowest index
    cur_req = "R7"; do_alloc(5000, 0); do_alloc(5000, 1); do_alloc(0, 1);
    cur_req = "R8";
    drive(1, 10, 1, 0, 0, 0);
    drive(1, 20, 0, 1, 9000, 9);           // ignored: scan running
    settle();
    do_alloc(9, 1);                        // would hit 9000 if release had landed
    cur_req = "R3";
    do_reset();
    for (int i = 0; i < N; i++) do_free(16'(100 * i + 10), 16'(5 + i));
    do_free(7000, 3);                      // table full
    do_free(7100, 0);                      // zero size
    cur_req = "R9";
    do_reset();
    drive(1, 64, 0, 1, 4000, 64); settle();          // only the release fits
    drive(1, 30, 1, 1, 4100, 300); settle();
    cur_req = "R4";
    for (int k = 0; k < 80; k++) begin
      int op;
      op = $urandom_range(0, 2);
      cur_req = (op == 2) ? "R9" : ((k % 2) ? "R5" : "R4");
      drive(op != 1, 16'($urandom_range(0, 300)), 1'($urandom_range(0, 1)),
            op != 0, 16'($urandom), 16'($urandom_range(0, 250)));
      settle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", cycles, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule